// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block works out the byte address for a single-register load or store and the value the base register should take afterwards. It takes the base register contents and an offset, then adds the offset to the base or subtracts it. The offset is either a 12-bit unsigned immediate or a register value shifted left by a 5-bit amount. All address arithmetic wraps modulo 2^AW.

Three indexing modes pick what goes out:

- **Pre-indexed, no writeback:** the access uses the computed sum and the base is returned unchanged.
- **Pre-indexed with writeback:** the sum is both the access address and the new base.
- **Post-indexed:** the access uses the untouched base and the sum becomes the new base.

Each request enters with a valid strobe. One clock later the results appear on registered outputs with a matching valid, together with a strobe that tells the register file to commit the new base.

Top module: `ldst_agen`

## Requirements
- R1: While rst_ni is low, out_valid_o, wb_en_o, addr_o and new_base_o are all zero.
- R2: out_valid_o is high exactly in the cycle after a clock edge at which in_valid_i was high, giving one cycle of latency.
- R3: When use_reg_i is 0, the offset is imm_i zero-extended to AW bits, and reg_ofs_i and shamt_i have no effect.
- R4: When use_reg_i is 1, the offset is reg_ofs_i shifted left by shamt_i, with bits above AW-1 dropped, and imm_i has no effect.
- R5: When sub_i is 1 the offset is subtracted from the base, otherwise it is added; both results wrap modulo 2^AW.
- R6: With post_i=0 and wb_i=0, addr_o is the computed sum, new_base_o equals base_i and wb_en_o is 0.
- R7: With post_i=0 and wb_i=1, both addr_o and new_base_o equal the computed sum and wb_en_o is 1.
- R8: With post_i=1, addr_o equals base_i, new_base_o is the computed sum and wb_en_o is 1, whatever the value of wb_i.
- R9: After an edge with in_valid_i low, out_valid_o and wb_en_o are 0 and addr_o and new_base_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request valid |
| base_i | input | AW | Base register value |
| imm_i | input | IMM_W | Unsigned immediate offset |
| reg_ofs_i | input | AW | Register offset value |
| shamt_i | input | SH_W | Left shift applied to register offset |
| use_reg_i | input | 1 | 1: register offset, 0: immediate |
| sub_i | input | 1 | 1: subtract offset, 0: add |
| post_i | input | 1 | 1: post-indexed, 0: pre-indexed |
| wb_i | input | 1 | Pre-indexed writeback request |
| out_valid_o | output | 1 | Result valid |
| addr_o | output | AW | Access address |
| new_base_o | output | AW | Updated base value |
| wb_en_o | output | 1 | Commit new_base_o to the base register |

## Verification
The sweep crosses every mode with both directions and both offset sources. It uses bases near zero and near the top of the address space, so a carry or borrow that is not allowed to wrap produces a wrong address. The shift amount is run through 0 to 31, so a truncated shifter or an off-by-one shift shows up at the high amounts. The unused offset source is always driven with junk, so a wrongly steered mux corrupts the sum. Post-indexed requests with wb_i both low and high expose a design that gates writeback on wb_i or swaps address and new base, and idle cycles expose outputs that fail to hold or a stray writeback strobe.

// File: rtl/ldst_agen_pkg.sv
package ldst_agen_pkg;
  typedef enum logic [1:0] {
    IDX_PRE      = 2'd0,
    IDX_PRE_WB   = 2'd1,
    IDX_POST     = 2'd2
  } idx_mode_e;

  function automatic idx_mode_e decode_mode(input logic post, input logic wb);
    if (post)    return IDX_POST;
    else if (wb) return IDX_PRE_WB;
    else         return IDX_PRE;
  endfunction
endpackage

// File: rtl/ldst_ofs_gen.sv
module ldst_ofs_gen #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IMM_W = 12,
  parameter int unsigned SH_W  = 5
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [AW-1:0]    reg_ofs_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic             use_reg_i,
  output logic [AW-1:0]    ofs_o
);
  logic [AW-1:0] imm_ext;
  logic [AW-1:0] reg_shl;

  generate
    if (AW > IMM_W) begin : g_zext
      assign imm_ext = {{(AW-IMM_W){1'b0}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[AW-1:0];
    end
  endgenerate

  assign reg_shl = reg_ofs_i << shamt_i;
  assign ofs_o   = use_reg_i ? reg_shl : imm_ext;
endmodule

// File: rtl/ldst_ofs_apply.sv
module ldst_ofs_apply #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ofs_i,
  input  logic          sub_i,
  output logic [AW-1:0] sum_o
);
  // single adder: subtract as base + ~ofs + 1
  logic [AW-1:0] ofs_x;
  assign ofs_x = sub_i ? ~ofs_i : ofs_i;
  assign sum_o = base_i + ofs_x + {{(AW-1){1'b0}}, sub_i};
endmodule

// File: rtl/ldst_mode_sel.sv
module ldst_mode_sel
  import ldst_agen_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  idx_mode_e     mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] sum_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] new_base_o,
  output logic          wb_en_o
);
  always_comb begin
    addr_o     = sum_i;
    new_base_o = base_i;
    wb_en_o    = 1'b0;
    unique case (mode_i)
      IDX_PRE_WB: begin
        new_base_o = sum_i;
        wb_en_o    = 1'b1;
      end
      IDX_POST: begin
        addr_o     = base_i;
        new_base_o = sum_i;
        wb_en_o    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_agen_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned IMM_W = 12,
  parameter int unsigned SH_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [AW-1:0]    base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [AW-1:0]    reg_ofs_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic             use_reg_i,
  input  logic             sub_i,
  input  logic             post_i,
  input  logic             wb_i,
  output logic             out_valid_o,
  output logic [AW-1:0]    addr_o,
  output logic [AW-1:0]    new_base_o,
  output logic             wb_en_o
);
  logic [AW-1:0] ofs;
  logic [AW-1:0] sum;
  logic [AW-1:0] addr_d;
  logic [AW-1:0] nb_d;
  logic          wb_d;
  idx_mode_e     mode;

  assign mode = decode_mode(post_i, wb_i);

  ldst_ofs_gen #(.AW(AW), .IMM_W(IMM_W), .SH_W(SH_W)) u_ofs_gen (
    .imm_i     (imm_i),
    .reg_ofs_i (reg_ofs_i),
    .shamt_i   (shamt_i),
    .use_reg_i (use_reg_i),
    .ofs_o     (ofs)
  );

  ldst_ofs_apply #(.AW(AW)) u_ofs_apply (
    .base_i (base_i),
    .ofs_i  (ofs),
    .sub_i  (sub_i),
    .sum_o  (sum)
  );

  ldst_mode_sel #(.AW(AW)) u_mode_sel (
    .mode_i     (mode),
    .base_i     (base_i),
    .sum_i      (sum),
    .addr_o     (addr_d),
    .new_base_o (nb_d),
    .wb_en_o    (wb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      wb_en_o     <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      wb_en_o     <= in_valid_i & wb_d;
    end
  end

  // data regs load only on a valid request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      new_base_o <= '0;
    end else if (in_valid_i) begin
      addr_o     <= addr_d;
      new_base_o <= nb_d;
    end
  end
endmodule

// File: rtl/ldst_agen_chk.sv
module ldst_agen_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IMM_W = 12,
  parameter int unsigned SH_W  = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [AW-1:0]    base_i,
  input logic             post_i,
  input logic             wb_i,
  input logic             out_valid_o,
  input logic [AW-1:0]    addr_o,
  input logic [AW-1:0]    new_base_o,
  input logic             wb_en_o
);
  always_comb begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (!out_valid_o && !wb_en_o && addr_o == '0 && new_base_o == '0);
    end
  end

  p_valid_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  p_pre_keep_base_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !post_i && !wb_i |=> new_base_o == $past(base_i) && !wb_en_o);

  p_pre_wb_same_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !post_i && wb_i |=> addr_o == new_base_o && wb_en_o);

  p_post_addr_base_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && post_i |=> addr_o == $past(base_i) && wb_en_o);

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && !wb_en_o && $stable(addr_o) && $stable(new_base_o));
endmodule

bind ldst_agen ldst_agen_chk #(.AW(AW), .IMM_W(IMM_W), .SH_W(SH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .base_i      (base_i),
  .post_i      (post_i),
  .wb_i        (wb_i),
  .out_valid_o (out_valid_o),
  .addr_o      (addr_o),
  .new_base_o  (new_base_o),
  .wb_en_o     (wb_en_o)
);

// File: tb/ldst_agen_bench.sv
`timescale 1ns/1ps
module ldst_agen_bench;
  localparam int AW = 32;
  localparam int IMM_W = 12;
  localparam int SH_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [AW-1:0]    base = '0;
  logic [IMM_W-1:0] imm = '0;
  logic [AW-1:0]    rofs = '0;
  logic [SH_W-1:0]  shamt = '0;
  logic             use_reg = 1'b0, sub = 1'b0, post = 1'b0, wb = 1'b0;
  logic             out_valid, wb_en;
  logic [AW-1:0]    addr, new_base;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ldst_agen #(.AW(AW), .IMM_W(IMM_W), .SH_W(SH_W)) u_ldst_agen (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .base_i(base),
    .imm_i(imm), .reg_ofs_i(rofs), .shamt_i(shamt), .use_reg_i(use_reg),
    .sub_i(sub), .post_i(post), .wb_i(wb), .out_valid_o(out_valid),
    .addr_o(addr), .new_base_o(new_base), .wb_en_o(wb_en)
  );

  task automatic check(input string req, input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one request: drive at negedge, sample 1 ns after the capturing edge
  task automatic run(input logic [AW-1:0] b, input logic [IMM_W-1:0] im,
                     input logic [AW-1:0] ro, input logic [SH_W-1:0] sh,
                     input logic ur, input logic sb, input logic ps, input logic w);
    logic [AW-1:0] ofs, sum, e_addr, e_nb;
    logic e_wb;
    string rq;
    @(negedge clk);
    base = b; imm = im; rofs = ro; shamt = sh; use_reg = ur; sub = sb; post = ps; wb = w;
    in_valid = 1'b1;
    ofs = ur ? (ro << sh) : AW'(im);  // R3 / R4
    sum = sb ? b - ofs : b + ofs;     // R5
    if (ps) begin e_addr = b; e_nb = sum; e_wb = 1'b1; rq = "R8"; end
    else if (w) begin e_addr = sum; e_nb = sum; e_wb = 1'b1; rq = "R7"; end
    else begin e_addr = sum; e_nb = b; e_wb = 1'b0; rq = "R6"; end
    @(posedge clk); #1;
    check("R2", "out_valid", AW'(out_valid), AW'(1));
    check(rq, ur ? "addr(R4)" : "addr(R3)", addr, e_addr);
    check(rq, sb ? "new_base(R5)" : "new_base", new_base, e_nb);
    check(rq, "wb_en", AW'(wb_en), AW'(e_wb));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle_check();
    logic [AW-1:0] a0, n0;
    a0 = addr; n0 = new_base;
    @(negedge clk);
    in_valid = 1'b0; base = ~base; imm = ~imm; post = ~post;
    @(posedge clk); #1;
    check("R9", "out_valid", AW'(out_valid), '0);
    check("R9", "wb_en", AW'(wb_en), '0);
    check("R9", "addr hold", addr, a0);
    check("R9", "new_base hold", new_base, n0);
  endtask

  initial begin
    logic [AW-1:0] bases [4];
    bases[0] = 32'h0000_0200; bases[1] = 32'h0000_0000;
    bases[2] = 32'hFFFF_FFF0; bases[3] = 32'h8000_0004;
    #5;
    check("R1", "out_valid", AW'(out_valid), '0);
    check("R1", "wb_en", AW'(wb_en), '0);
    check("R1", "addr", addr, '0);
    check("R1", "new_base", new_base, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // worked examples
    run(32'h200, 12'd4, 32'hDEAD, 5'd7, 1'b0, 1'b1, 1'b0, 1'b1);   // R7 -> 0x1fc
    run(32'h200, 12'd12, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0);     // R8 0x200 / 0x20c
    run(32'h200, 12'hABC, 32'd3, 5'd2, 1'b1, 1'b0, 1'b1, 1'b0);    // R4 -> 0x20c
    run(32'h200, 12'd12, 32'h55, 5'd9, 1'b0, 1'b1, 1'b1, 1'b1);    // R5 -> 0x1f4
    idle_check();
    for (int bi = 0; bi < 4; bi++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < 2; s++) begin
          // immediate offsets incl. max 0xFFF; junk on register path
          run(bases[bi], 12'hFFF, 32'hFFFF_FFFF, 5'd31, 1'b0, s[0], m[1], m[0]);
          run(bases[bi], 12'h024, 32'h1234_5678, 5'd3, 1'b0, s[0], m[1], m[0]);
          for (int sh = 0; sh < 32; sh++) begin
            run(bases[bi], 12'h7A5, 32'h0000_0013 + AW'(sh), sh[SH_W-1:0],
                1'b1, s[0], m[1], m[0]);
          end
        end
      end
      idle_check();
    end
    // wrap checks
    run(32'h0, 12'd4, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0);           // R5 -> 0xfffffffc
    run(32'hFFFF_FFF0, 12'h020, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1); // R5 -> 0x10
    idle_check();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule